// File: doc/BRIEF.md
# Duplex-Aware FIFO DMA Request Controller

This block sits between a host bus engine and the transmit and receive FIFOs of an Ethernet MAC and decides, cycle by cycle, when each direction asks the bus engine for a DMA transfer. On the transmit side it compares the free space reported by the FIFO against a programmable watermark. On the receive side it compares the stored data against a second watermark and also tracks whole frames left in the FIFO.

The rules depend on the duplex mode. In half duplex a collision can force a frame to be resent, so the opening 64 bytes of each transmitted frame are kept in the FIFO until 512 bit times (64 byte strobes) have gone out or the frame ends. While those bytes are held they still occupy space, so the transmit request needs that much more room. Also in half duplex, unless short-frame acceptance is on, receive DMA for a frame stays blocked until 64 good bytes of it have arrived. In full duplex, and in half duplex with short-frame acceptance, no bytes are held back and a receive request is raised by the watermark or by any complete good frame.

All three outputs are registered. Each reflects the inputs sampled at the previous rising edge.

Top module: `dma_req_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, tx_dma_req, rx_dma_req and head_hold are all 0 after that edge.
- R2: A 2-bit watermark code sel gives a threshold of 16 << sel bytes: 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128. tx_wm_sel sets the free-space threshold and rx_wm_sel sets the stored-data threshold.
- R3: In half duplex, tx_dma_req after an edge equals (tx_free >= threshold + H) sampled at that edge. H is the number of bytes counted by the head counter while head_hold is 1, and 0 otherwise. The request drops the cycle after this condition lapses.
- R4: In full duplex (full_duplex = 1), head_hold is 0 after every edge and tx_dma_req after an edge equals (tx_free >= threshold) sampled at that edge.
- R5: In half duplex, a tx_frame_start pulse sets head_hold and clears the head counter. Each tx_byte_sent pulse while head_hold is 1 adds one to the counter. head_hold clears at the edge that samples the 64th such pulse.
- R6: A tx_frame_end pulse while head_hold is 1 clears it. A tx_collision pulse while head_hold is 1 restarts the counter at 0 and leaves head_hold set. Collisions and byte pulses while head_hold is 0 have no effect.
- R7: In half duplex with runt_accept = 0, rx_dma_req is 0 from the edge after rx_frame_start until the edge after either the 64th rx_byte_ok pulse of that frame or rx_frame_end.
- R8: When not blocked by R7, rx_dma_req after an edge equals (rx_used >= threshold OR frame_waiting) sampled at that edge.
- R9: An rx_frame_end pulse with rx_frame_good = 1 sets frame_waiting in full duplex or with runt_accept = 1, whatever the frame length. In half duplex with runt_accept = 0 it sets frame_waiting only if the frame reached 64 good bytes. frame_waiting clears at an edge where rx_used = 0 and no such pulse is sampled. A frame ending with rx_frame_good = 0 never sets it.
- R10: In half duplex with runt_accept = 1, the receive request follows the full-duplex rules exactly, with no head blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| runt_accept | input | 1 | Half duplex: allow early receive DMA and frames shorter than 64 bytes |
| tx_wm_sel | input | 2 | Transmit free-space watermark code |
| rx_wm_sel | input | 2 | Receive stored-data watermark code |
| tx_free | input | CW | Free bytes in transmit FIFO, not counting held head bytes |
| rx_used | input | CW | Bytes stored in receive FIFO |
| tx_frame_start | input | 1 | Pulse: MAC begins sending a frame |
| tx_frame_end | input | 1 | Pulse: MAC finished sending the frame |
| tx_byte_sent | input | 1 | Pulse: one byte left on the wire |
| tx_collision | input | 1 | Pulse: collision seen during transmit |
| rx_frame_start | input | 1 | Pulse: a new frame begins arriving |
| rx_byte_ok | input | 1 | Pulse: one byte received without error |
| rx_frame_end | input | 1 | Pulse: receive frame finished |
| rx_frame_good | input | 1 | Qualifies rx_frame_end: frame valid |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| head_hold | output | 1 | Keep the transmit frame head in the FIFO |

CW is $clog2(FIFO_DEPTH)+1, which is 9 with the default parameters.

## Verification
Every output is due exactly one rising edge after the inputs that decide it. The bench therefore drives stimulus just after a falling edge and lets a behavioural model take the same inputs at the next rising edge. At the following falling edge it compares all three outputs against the model, on every cycle. The model keeps the head byte count, the receive good-byte count and the waiting-frame flag as plain integers. This means a counter that is off by one cycle, or a head release that comes at the 63rd or 65th byte instead of the 64th, shows up as a mismatch. Directed sequences put each watermark code at its threshold and one byte either side, in both duplex modes. They also send collisions before and after release, early frame ends, and short and long receive frames, both good and bad, with short-frame acceptance on and off.

// File: rtl/dma_req_pkg.sv
// Shared types for the DMA request controller.
// Assumes: the watermark code is 2 bits and each step doubles the threshold.
package dma_req_pkg;
    typedef enum logic [1:0] {
        WM_X1 = 2'd0,
        WM_X2 = 2'd1,
        WM_X4 = 2'd2,
        WM_X8 = 2'd3
    } wm_code_e;
endpackage

// File: rtl/dma_wm_decode.sv
// Turns a 2-bit watermark code into a byte threshold: BASE, 2*BASE, 4*BASE or 8*BASE.
// Assumes: SW is wide enough to hold 8*BASE.
module dma_wm_decode
    import dma_req_pkg::*;
#(
    parameter int SW   = 11,
    parameter int BASE = 16
) (
    input  logic [1:0]    sel,
    output logic [SW-1:0] thresh
);
    // Map each code to its byte count.
    always_comb begin
        case (wm_code_e'(sel))
            WM_X1:   thresh = SW'(BASE);
            WM_X2:   thresh = SW'(BASE * 2);
            WM_X4:   thresh = SW'(BASE * 4);
            default: thresh = SW'(BASE * 8);
        endcase
    end
endmodule

// File: rtl/dma_tx_head_ctrl.sv
// Transmit side of the controller. In half duplex it holds the head of each frame
// until HEAD_BYTES bytes have been sent or the frame ends. A collision during the
// hold restarts the count. It raises tx_dma_req when the free space, less the bytes
// still held, reaches the watermark.
// Assumes: tx_frame_start is not pulsed in the same cycle as any other transmit strobe,
// and the FIFO reports tx_free without counting the held bytes.
module dma_tx_head_ctrl #(
    parameter int CW         = 9,
    parameter int SW         = 11,
    parameter int HEAD_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full_duplex,
    input  logic          tx_frame_start,
    input  logic          tx_frame_end,
    input  logic          tx_byte_sent,
    input  logic          tx_collision,
    input  logic [CW-1:0] tx_free,
    input  logic [SW-1:0] thresh,
    output logic          head_hold,
    output logic          tx_dma_req
);
    localparam int HCW = $clog2(HEAD_BYTES + 1);
    localparam logic [HCW-1:0] LAST_BYTE = HCW'(HEAD_BYTES - 1);

    logic           hold_q;
    logic [HCW-1:0] cnt_q;
    logic [SW-1:0]  retained;
    logic [SW-1:0]  need;
    logic           req_d;

    // Bytes still held count against the free space.
    assign retained = hold_q ? SW'(cnt_q) : '0;
    assign need     = thresh + retained;
    assign req_d    = SW'(tx_free) >= need;

    // Head retention state and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (full_duplex) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (tx_frame_start) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
        end else if (hold_q) begin
            if (tx_frame_end) begin
                hold_q <= 1'b0;
            end else if (tx_collision) begin
                cnt_q <= '0;
            end else if (tx_byte_sent) begin
                if (cnt_q == LAST_BYTE) begin
                    hold_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Registered transmit request.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_dma_req <= 1'b0;
        else        tx_dma_req <= req_d;
    end

    assign head_hold = hold_q;

    // R4: full duplex never holds the head.
    a_r4_fd_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !head_hold);
    // R6: a frame end during the hold releases it.
    a_r6_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (head_hold && tx_frame_end && !tx_frame_start) |=> !head_hold);
    // R6: once released, only a new frame start can bring the hold back.
    a_r6_no_rehold: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_hold && !tx_frame_start) |=> !head_hold);
    // R5: the counter stays below the head size while holding.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (cnt_q < HCW'(HEAD_BYTES)));
endmodule

// File: rtl/dma_rx_gate.sv
// Receive side of the controller. In half duplex without short-frame acceptance it
// blocks requests until HEAD_BYTES good bytes of a frame have arrived or the frame
// ends. It keeps a flag while a complete good frame sits in the FIFO.
// Assumes: rx_frame_start never comes in the same cycle as a byte or end strobe.
module dma_rx_gate #(
    parameter int CW         = 9,
    parameter int SW         = 11,
    parameter int HEAD_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full_duplex,
    input  logic          runt_accept,
    input  logic          rx_frame_start,
    input  logic          rx_byte_ok,
    input  logic          rx_frame_end,
    input  logic          rx_frame_good,
    input  logic [CW-1:0] rx_used,
    input  logic [SW-1:0] thresh,
    output logic          rx_dma_req
);
    localparam int HCW = $clog2(HEAD_BYTES + 1);
    localparam logic [HCW-1:0] HEAD_CNT  = HCW'(HEAD_BYTES);
    localparam logic [HCW-1:0] LAST_BYTE = HCW'(HEAD_BYTES - 1);

    logic           early_ok;
    logic           block_q;
    logic           wait_q;
    logic [HCW-1:0] cnt_q;
    logic           wait_set;
    logic           req_d;

    assign early_ok = full_duplex | runt_accept;
    assign wait_set = rx_frame_end & rx_frame_good & (early_ok | (cnt_q == HEAD_CNT));
    assign req_d    = !block_q && ((SW'(rx_used) >= thresh) || wait_q);

    // Good-byte counter for the frame now arriving, saturating at the head size.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (rx_frame_start)                 cnt_q <= '0;
        else if (rx_byte_ok && cnt_q != HEAD_CNT) cnt_q <= cnt_q + 1'b1;
    end

    // Head-of-frame block for half duplex without short-frame acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  block_q <= 1'b0;
        else if (early_ok)                           block_q <= 1'b0;
        else if (rx_frame_start)                     block_q <= 1'b1;
        else if (rx_frame_end)                       block_q <= 1'b0;
        else if (rx_byte_ok && cnt_q == LAST_BYTE)   block_q <= 1'b0;
    end

    // Whole-frame-waiting flag, cleared once the FIFO is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)            wait_q <= 1'b0;
        else if (wait_set)     wait_q <= 1'b1;
        else if (rx_used == '0) wait_q <= 1'b0;
    end

    // Registered receive request.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_dma_req <= 1'b0;
        else        rx_dma_req <= req_d;
    end

    // R7: no request follows a blocked cycle.
    a_r7_block_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        block_q |=> !rx_dma_req);
    // R10: early mode never leaves the head block set.
    a_r10_early_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        early_ok |=> !block_q);
    // R9: a bad frame end on an empty FIFO leaves no waiting frame.
    a_r9_bad_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_end && !rx_frame_good && rx_used == '0) |=> !wait_q);
    // R7: the good-byte counter never passes the head size.
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HEAD_CNT);
endmodule

// File: rtl/dma_req_ctrl.sv
// Top of the duplex-aware DMA request controller. It decodes both watermark codes and
// drives the transmit head/request unit and the receive gating unit.
// Assumes: full_duplex and runt_accept change only between frames.
module dma_req_ctrl #(
    parameter int FIFO_DEPTH = 256,
    parameter int WM_BASE    = 16,
    parameter int HEAD_BYTES = 64,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full_duplex,
    input  logic          runt_accept,
    input  logic [1:0]    tx_wm_sel,
    input  logic [1:0]    rx_wm_sel,
    input  logic [CW-1:0] tx_free,
    input  logic [CW-1:0] rx_used,
    input  logic          tx_frame_start,
    input  logic          tx_frame_end,
    input  logic          tx_byte_sent,
    input  logic          tx_collision,
    input  logic          rx_frame_start,
    input  logic          rx_byte_ok,
    input  logic          rx_frame_end,
    input  logic          rx_frame_good,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          head_hold
);
    localparam int SW = CW + 2;

    logic [SW-1:0] tx_thr;
    logic [SW-1:0] rx_thr;

    dma_wm_decode #(.SW(SW), .BASE(WM_BASE)) u_tx_wm (.sel(tx_wm_sel), .thresh(tx_thr));
    dma_wm_decode #(.SW(SW), .BASE(WM_BASE)) u_rx_wm (.sel(rx_wm_sel), .thresh(rx_thr));

    dma_tx_head_ctrl #(.CW(CW), .SW(SW), .HEAD_BYTES(HEAD_BYTES)) u_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .full_duplex    (full_duplex),
        .tx_frame_start (tx_frame_start),
        .tx_frame_end   (tx_frame_end),
        .tx_byte_sent   (tx_byte_sent),
        .tx_collision   (tx_collision),
        .tx_free        (tx_free),
        .thresh         (tx_thr),
        .head_hold      (head_hold),
        .tx_dma_req     (tx_dma_req)
    );

    dma_rx_gate #(.CW(CW), .SW(SW), .HEAD_BYTES(HEAD_BYTES)) u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .full_duplex    (full_duplex),
        .runt_accept    (runt_accept),
        .rx_frame_start (rx_frame_start),
        .rx_byte_ok     (rx_byte_ok),
        .rx_frame_end   (rx_frame_end),
        .rx_frame_good  (rx_frame_good),
        .rx_used        (rx_used),
        .thresh         (rx_thr),
        .rx_dma_req     (rx_dma_req)
    );

    // R3: free space below the bare watermark never yields a transmit request.
    a_r3_tx_below_wm: assert property (@(posedge clk) disable iff (!rst_n)
        (SW'(tx_free) < tx_thr) |=> !tx_dma_req);
    // R2: the smallest code gives the base threshold.
    a_r2_base_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wm_sel == 2'd0) |-> (tx_thr == SW'(WM_BASE)));
endmodule

// File: tb/tb_dma_req_ctrl.sv
`timescale 1ns/100ps
module tb_dma_req_ctrl;
    localparam int CW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, runt_accept = 1'b0;
    logic [1:0] tx_wm_sel = '0, rx_wm_sel = '0;
    logic [CW-1:0] tx_free = '0, rx_used = '0;
    logic tx_frame_start = 0, tx_frame_end = 0, tx_byte_sent = 0, tx_collision = 0;
    logic rx_frame_start = 0, rx_byte_ok = 0, rx_frame_end = 0, rx_frame_good = 0;
    logic tx_dma_req, rx_dma_req, head_hold;

    always #2.5 clk = ~clk;

    dma_req_ctrl dut (.*);

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // Behavioural reference state.
    int m_hold, m_tcnt, m_blk, m_rcnt, m_wait;
    int e_tx, e_rx, e_hold;
    int thr_t, thr_r, setw;

    function automatic int wm(input logic [1:0] s);
        return 16 << s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 0; m_tcnt = 0; m_blk = 0; m_rcnt = 0; m_wait = 0;
            e_tx = 0; e_rx = 0; e_hold = 0;
        end else begin
            thr_t = wm(tx_wm_sel);
            thr_r = wm(rx_wm_sel);
            e_tx = (int'(tx_free) >= thr_t + (m_hold ? m_tcnt : 0));
            e_rx = (!m_blk) && ((int'(rx_used) >= thr_r) || m_wait);
            if (full_duplex) begin m_hold = 0; m_tcnt = 0; end
            else if (tx_frame_start) begin m_hold = 1; m_tcnt = 0; end
            else if (m_hold) begin
                if (tx_frame_end) m_hold = 0;
                else if (tx_collision) m_tcnt = 0;
                else if (tx_byte_sent) begin
                    m_tcnt++;
                    if (m_tcnt == 64) begin m_hold = 0; m_tcnt = 0; end
                end
            end
            e_hold = m_hold;
            setw = rx_frame_end && rx_frame_good && (full_duplex || runt_accept || m_rcnt >= 64);
            if (full_duplex || runt_accept) m_blk = 0;
            else if (rx_frame_start) m_blk = 1;
            else if (rx_frame_end) m_blk = 0;
            else if (rx_byte_ok && m_rcnt == 63) m_blk = 0;
            if (setw) m_wait = 1;
            else if (rx_used == 0) m_wait = 0;
            if (rx_frame_start) m_rcnt = 0;
            else if (rx_byte_ok && m_rcnt < 64) m_rcnt++;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(int'(tx_dma_req), e_tx, "tx_dma_req");
            chk(int'(rx_dma_req), e_rx, "rx_dma_req");
            chk(int'(head_hold), e_hold, "head_hold");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; cyc(1); s = 1'b0;
    endtask

    task automatic tx_bytes(input int n);
        for (int i = 0; i < n; i++) begin pulse(tx_byte_sent); cyc(1); end
    endtask

    task automatic rx_bytes(input int n);
        for (int i = 0; i < n; i++) begin pulse(rx_byte_ok); end
    endtask

    task automatic wm_sweep();
        for (int s = 0; s < 4; s++) begin
            for (int d = -1; d <= 1; d++) begin
                cyc(1);
                tx_wm_sel = 2'(s); rx_wm_sel = 2'(s);
                tx_free = CW'(wm(2'(s)) + d); rx_used = CW'(wm(2'(s)) + d);
                cyc(2);
                chk(int'(tx_dma_req), int'(d >= 0), "R2 tx threshold");
                chk(int'(rx_dma_req), int'(d >= 0), "R2 rx threshold");
            end
        end
    endtask

    initial begin
        cyc(4);
        cur_req = "R1";
        chk(int'(tx_dma_req) + int'(rx_dma_req) + int'(head_hold), 0, "R1 reset outputs");
        rst_n = 1'b1;

        cur_req = "R4"; full_duplex = 1; wm_sweep();
        cur_req = "R3"; full_duplex = 0; wm_sweep();

        // R5/R6: half duplex transmit head retention.
        cur_req = "R5"; tx_wm_sel = 0; tx_free = 40; rx_used = 0; cyc(2);
        pulse(tx_frame_start); cyc(1);
        chk(int'(head_hold), 1, "R5 hold after start");
        tx_bytes(30);
        chk(int'(tx_dma_req), 0, "R3 retained bytes lower request");
        cur_req = "R6"; pulse(tx_collision); cyc(1);
        chk(int'(head_hold), 1, "R6 collision keeps hold");
        cur_req = "R5"; tx_bytes(63);
        chk(int'(head_hold), 1, "R5 still held at 63");
        tx_bytes(1);
        chk(int'(head_hold), 0, "R5 released at 64");
        cur_req = "R6"; pulse(tx_collision); tx_bytes(5); cyc(1);
        chk(int'(head_hold), 0, "R6 late collision ignored");
        pulse(tx_frame_end); cyc(2);
        pulse(tx_frame_start); tx_bytes(10); pulse(tx_frame_end); cyc(1);
        chk(int'(head_hold), 0, "R6 early end releases");
        cur_req = "R4"; full_duplex = 1; cyc(1);
        pulse(tx_frame_start); tx_bytes(20);
        chk(int'(head_hold), 0, "R4 no hold in full duplex");
        pulse(tx_frame_end); cyc(2);

        // R7: half duplex receive head block.
        cur_req = "R7"; full_duplex = 0; runt_accept = 0; rx_wm_sel = 0; rx_used = 100; cyc(2);
        pulse(rx_frame_start); rx_bytes(63); cyc(1);
        chk(int'(rx_dma_req), 0, "R7 blocked before 64 bytes");
        rx_bytes(1); cyc(1);
        chk(int'(rx_dma_req), 1, "R7 opens at 64 bytes");
        rx_frame_good = 1; pulse(rx_frame_end); rx_frame_good = 0;
        cur_req = "R9"; rx_used = 8; cyc(2);
        chk(int'(rx_dma_req), 1, "R9 long frame waiting");
        rx_used = 0; cyc(3);
        // Short frame, half duplex, no runt accept: never waits.
        rx_used = 8; pulse(rx_frame_start); rx_bytes(20);
        rx_frame_good = 1; pulse(rx_frame_end); rx_frame_good = 0; cyc(2);
        chk(int'(rx_dma_req), 0, "R9 runt not waiting");
        rx_used = 0; cyc(2);

        // R10: runt accept in half duplex.
        cur_req = "R10"; runt_accept = 1; rx_used = 8;
        pulse(rx_frame_start); rx_bytes(20);
        rx_frame_good = 1; pulse(rx_frame_end); rx_frame_good = 0; cyc(2);
        chk(int'(rx_dma_req), 1, "R10 runt frame waiting");
        rx_used = 0; cyc(3);
        chk(int'(rx_dma_req), 0, "R9 wait cleared on empty");
        rx_used = 20; pulse(rx_frame_start); cyc(2);
        chk(int'(rx_dma_req), 1, "R10 no head block");

        // R8/R9: full duplex, good and bad short frames.
        cur_req = "R8"; runt_accept = 0; full_duplex = 1; rx_used = 4;
        pulse(rx_frame_start); rx_bytes(10);
        pulse(rx_frame_end); cyc(2);
        chk(int'(rx_dma_req), 0, "R8 bad frame no request");
        pulse(rx_frame_start); rx_bytes(10);
        rx_frame_good = 1; pulse(rx_frame_end); rx_frame_good = 0; cyc(2);
        chk(int'(rx_dma_req), 1, "R9 good short frame in full duplex");
        rx_used = 0; cyc(4);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule